// File: doc/BRIEF.md
# Page Write Loader with Busy Polling

This block collects a burst of single-byte writes into a one-page staging buffer and then starts an internal programming pass on its own. No explicit start command exists. Programming begins once the load window has elapsed with no further byte arriving, and every accepted byte restarts that window. During the programming pass, the block hands the loaded bytes to the array model one per clock, in ascending offset order, as a stream of commit beats. While busy, it answers host reads with a status byte. That byte carries the complement of the last loaded byte's top bit, plus a bit that flips on every output-enable pulse.

The host side uses active-low chip select, output enable and write enable, all synchronous to the block clock. A write is taken at the rising edge of write enable, and only if the low phase lasted long enough. A command decoder supplies a protection flag. While that flag is set, a page is accepted only after a three-write unlock sequence. The load window and the programming time are cycle counts set by parameters. The page size must not exceed the programming time.

Top module: `pageWriteLoader`

## Requirements
- R1: After reset, busy, commitValid and rdDrive are low and rdData is 8'h00.
- R2: A write registers on the clock where weN is sampled high after at least MIN_WE_LOW consecutive low samples. A shorter low pulse is not a write and loads nothing.
- R3: While weN rises, a write with ceN high or oeN low is inhibited and loads nothing.
- R4: The first accepted byte of a page fixes the page number as addr[15:7]. Each later byte uses only addr[6:0] as its offset, and every commit address equals {page, offset}.
- R5: Every accepted byte restarts the load window. busy rises exactly LOAD_WINDOW clocks after the clock that took the last accepted byte.
- R6: busy stays high for exactly PROG_CYCLES clocks.
- R7: In the first PAGE_BYTES clocks of programming, commitValid pulses once for each loaded offset, in ascending offset order. commitData is the last value written to that offset. No unloaded offset is committed.
- R8: With protectOn high, bytes are loaded only after the writes AAh to 5555h, 55h to 2AAAh and A0h to 5555h, compared on addr[14:0]. Without that sequence, bytes are discarded and busy never rises. The unlock writes are not loaded, and the unlock is used up once programming starts.
- R9: While busy, rdDrive is high when ceN and oeN are both low. rdData[7] is the complement of bit 7 of the last loaded byte, and rdData[5:0] is zero.
- R10: rdData[6] inverts on each oeN falling edge taken with ceN low while busy, and it holds at all other times. Once busy falls, rdData[7] shows the true bit 7 of the last loaded byte.
- R11: Writes that arrive while busy are ignored. They neither add commits nor change busy length or status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| weN | input | 1 | Write enable, active low |
| ceN | input | 1 | Chip select, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| dataIn | input | DATA_W | Write data |
| protectOn | input | 1 | Software protection active, from command decoder |
| busy | output | 1 | Programming pass in progress |
| commitValid | output | 1 | One staged byte offered to the array this clock |
| commitAddr | output | ADDR_W | Array address of the offered byte |
| commitData | output | DATA_W | Value of the offered byte |
| rdDrive | output | 1 | Status byte should drive the read bus |
| rdData | output | DATA_W | Polling status byte |

## Verification
Several checks hold on every cycle:
- commit beats occur only inside a programming pass;
- the staging mask stays frozen while busy and is empty afterwards;
- the toggle bit holds outside programming;
- no byte enters the buffer under protection without a full unlock;
- busy can only be entered from the loading state.

Other properties are visible only in the bench scenarios:
- the exact window and busy lengths;
- the ascending order of the commit stream;
- last-write-wins on a repeated offset;
- rejection of short pulses and inhibited writes;
- status complement and toggle values across successive reads.

// File: rtl/pwlPkg.sv
package pwlPkg;

  typedef enum logic [1:0] {
    PS_IDLE,
    PS_LOAD,
    PS_PROG
  } pwlState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadEn;     // accepted byte this clock
    logic firstLoad;  // accepted byte opens a new page
    logic clrMask;    // last programming clock: empty the buffer
    logic progActive; // programming pass running
    logic streamOn;   // commit stream window
  } pwlStrobes_t;

endpackage

// File: rtl/pwlControl.sv
module pwlControl
  import pwlPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 128,
  parameter int LOAD_WINDOW = 10000,
  parameter int PROG_CYCLES = 500000,
  parameter int MIN_WE_LOW  = 2,
  localparam int OFF_W      = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              weN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic [14:0]       cmdAddr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              protectOn,
  output pwlStrobes_t       ctl,
  output logic [OFF_W-1:0]  streamIdx,
  output logic              busy
);

  localparam int LWIN_W = $clog2(LOAD_WINDOW + 1);
  localparam int PROG_W = $clog2(PROG_CYCLES + 1);
  localparam int LOWC_W = $clog2(MIN_WE_LOW + 1);
  localparam logic [LWIN_W-1:0] LWIN_LAST = LWIN_W'(LOAD_WINDOW - 1);
  localparam logic [PROG_W-1:0] PROG_LAST = PROG_W'(PROG_CYCLES - 1);
  localparam logic [PROG_W-1:0] STREAM_END = PROG_W'(PAGE_BYTES);
  localparam logic [LOWC_W-1:0] LOW_SAT = LOWC_W'(MIN_WE_LOW);
  localparam logic [14:0] UNLOCK_ADR_A = 15'h5555;
  localparam logic [14:0] UNLOCK_ADR_B = 15'h2AAA;
  localparam logic [DATA_W-1:0] UNLOCK_D0 = DATA_W'(8'hAA);
  localparam logic [DATA_W-1:0] UNLOCK_D1 = DATA_W'(8'h55);
  localparam logic [DATA_W-1:0] UNLOCK_D2 = DATA_W'(8'hA0);

  pwlState_e         state;
  logic [LWIN_W-1:0] timer;
  logic [PROG_W-1:0] progCnt;
  logic [LOWC_W-1:0] lowCnt;
  logic [1:0]        unlockStage;
  logic              writeStb;
  logic              accept;
  logic              firstStep;
  logic              windowDone;
  logic              progDone;

  // Write-enable low-time filter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (weN) begin
      lowCnt <= '0;
    end else if (lowCnt != LOW_SAT) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  assign writeStb   = weN && (lowCnt == LOW_SAT) && !ceN && oeN;
  assign accept     = writeStb && (state != PS_PROG) &&
                      (!protectOn || (unlockStage == 2'd3));
  assign firstStep  = (cmdAddr == UNLOCK_ADR_A) && (dataIn == UNLOCK_D0);
  assign windowDone = (state == PS_LOAD) && !accept && (timer == LWIN_LAST);
  assign progDone   = (state == PS_PROG) && (progCnt == PROG_LAST);

  // Unlock sequence tracker
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlockStage <= 2'd0;
    end else if (windowDone) begin
      unlockStage <= 2'd0;
    end else if (writeStb && protectOn && (state != PS_PROG) &&
                 (unlockStage != 2'd3)) begin
      unique case (unlockStage)
        2'd0: unlockStage <= firstStep ? 2'd1 : 2'd0;
        2'd1: unlockStage <= ((cmdAddr == UNLOCK_ADR_B) && (dataIn == UNLOCK_D1)) ? 2'd2 :
                             (firstStep ? 2'd1 : 2'd0);
        default: unlockStage <= ((cmdAddr == UNLOCK_ADR_A) && (dataIn == UNLOCK_D2)) ? 2'd3 :
                                (firstStep ? 2'd1 : 2'd0);
      endcase
    end
  end

  // Main sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= PS_IDLE;
      timer   <= '0;
      progCnt <= '0;
    end else begin
      unique case (state)
        PS_IDLE: begin
          if (accept) begin
            state <= PS_LOAD;
            timer <= '0;
          end
        end
        PS_LOAD: begin
          if (accept) begin
            timer <= '0;
          end else if (windowDone) begin
            state   <= PS_PROG;
            progCnt <= '0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        PS_PROG: begin
          if (progDone) begin
            state <= PS_IDLE;
          end else begin
            progCnt <= progCnt + 1'b1;
          end
        end
        default: state <= PS_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.loadEn     = accept;
    ctl.firstLoad  = accept && (state == PS_IDLE);
    ctl.clrMask    = progDone;
    ctl.progActive = (state == PS_PROG);
    ctl.streamOn   = (state == PS_PROG) && (progCnt < STREAM_END);
  end

  assign streamIdx = progCnt[OFF_W-1:0];
  assign busy      = (state == PS_PROG);

  AST_PROT_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadEn && protectOn) |-> (unlockStage == 2'd3)); // R8

  AST_BUSY_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(state) == PS_LOAD)); // R5

endmodule

// File: rtl/pwlDatapath.sv
module pwlDatapath
  import pwlPkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 128,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwlStrobes_t       ctl,
  input  logic [OFF_W-1:0]  streamIdx,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              ceN,
  input  logic              oeN,
  output logic              commitValid,
  output logic [ADDR_W-1:0] commitAddr,
  output logic [DATA_W-1:0] commitData,
  output logic              rdDrive,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0]     bufMem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] bufMask;
  logic [PAGE_BYTES-1:0] hitVec;
  logic [PAGE_W-1:0]     pageQ;
  logic [DATA_W-1:0]     lastQ;
  logic                  togQ;
  logic                  oeNq;
  logic                  readFall;
  logic [OFF_W-1:0]      loadOff;

  assign loadOff = addr[OFF_W-1:0];

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_hit
    assign hitVec[i] = ctl.loadEn && (loadOff == OFF_W'(i));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufMask <= '0;
    end else if (ctl.clrMask) begin
      bufMask <= '0;
    end else begin
      bufMask <= bufMask | hitVec;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.loadEn) begin
      bufMem[loadOff] <= dataIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageQ <= '0;
      lastQ <= '0;
    end else if (ctl.loadEn) begin
      lastQ <= dataIn;
      if (ctl.firstLoad) begin
        pageQ <= addr[ADDR_W-1:OFF_W];
      end
    end
  end

  // Toggle bit driven by output-enable falling edges while busy
  assign readFall = !ceN && oeNq && !oeN && ctl.progActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oeNq <= 1'b1;
      togQ <= 1'b0;
    end else begin
      oeNq <= oeN;
      if (readFall) begin
        togQ <= ~togQ;
      end
    end
  end

  assign commitValid = ctl.streamOn && bufMask[streamIdx];
  assign commitAddr  = {pageQ, streamIdx};
  assign commitData  = bufMem[streamIdx];
  assign rdDrive     = ctl.progActive && !ceN && !oeN;

  always_comb begin
    rdData           = '0;
    rdData[DATA_W-1] = lastQ[DATA_W-1] ^ ctl.progActive;
    rdData[DATA_W-2] = togQ;
  end

  AST_COMMIT_IN_PROG: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> ctl.progActive); // R7

  AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.progActive && !ctl.clrMask) |=> $stable(bufMask)); // R11

  AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrMask |=> (bufMask == '0)); // R7

  AST_TOGGLE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.progActive |=> $stable(togQ)); // R10

endmodule

// File: rtl/pageWriteLoader.sv
module pageWriteLoader
  import pwlPkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 128,
  parameter int LOAD_WINDOW = 10000,
  parameter int PROG_CYCLES = 500000,
  parameter int MIN_WE_LOW  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              weN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              protectOn,
  output logic              busy,
  output logic              commitValid,
  output logic [ADDR_W-1:0] commitAddr,
  output logic [DATA_W-1:0] commitData,
  output logic              rdDrive,
  output logic [DATA_W-1:0] rdData
);

  localparam int OFF_W = $clog2(PAGE_BYTES);

  pwlStrobes_t      ctl;
  logic [OFF_W-1:0] streamIdx;

  pwlControl #(
    .DATA_W      (DATA_W),
    .PAGE_BYTES  (PAGE_BYTES),
    .LOAD_WINDOW (LOAD_WINDOW),
    .PROG_CYCLES (PROG_CYCLES),
    .MIN_WE_LOW  (MIN_WE_LOW)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .weN       (weN),
    .ceN       (ceN),
    .oeN       (oeN),
    .cmdAddr   (addr[14:0]),
    .dataIn    (dataIn),
    .protectOn (protectOn),
    .ctl       (ctl),
    .streamIdx (streamIdx),
    .busy      (busy)
  );

  pwlDatapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .streamIdx   (streamIdx),
    .addr        (addr),
    .dataIn      (dataIn),
    .ceN         (ceN),
    .oeN         (oeN),
    .commitValid (commitValid),
    .commitAddr  (commitAddr),
    .commitData  (commitData),
    .rdDrive     (rdDrive),
    .rdData      (rdData)
  );

endmodule

// File: tb/sim_pageWriteLoader.sv
module sim_pageWriteLoader;

  localparam int W = 40;
  localparam int P = 160;
  localparam int MINLOW = 2;

  logic clk = 1'b0;
  logic rstN, weN, ceN, oeN, protectOn;
  logic [15:0] addr;
  logic [7:0] dataIn;
  logic busy, commitValid, rdDrive;
  logic [15:0] commitAddr;
  logic [7:0] commitData, rdData;

  always #10 clk = ~clk;

  pageWriteLoader #(
    .LOAD_WINDOW (W),
    .PROG_CYCLES (P),
    .MIN_WE_LOW  (MINLOW)
  ) u0 (
    .clk(clk), .rstN(rstN), .weN(weN), .ceN(ceN), .oeN(oeN),
    .addr(addr), .dataIn(dataIn), .protectOn(protectOn),
    .busy(busy), .commitValid(commitValid), .commitAddr(commitAddr),
    .commitData(commitData), .rdDrive(rdDrive), .rdData(rdData)
  );

  // {addr, data, idle gap after}
  localparam logic [31:0] VEC [6] = '{
    {16'h3A05, 8'h11, 8'd3},
    {16'h3A7F, 8'hC3, 8'd10},
    {16'h1200, 8'h5A, 8'd20},
    {16'h3A05, 8'hE7, 8'd35},
    {16'h3A40, 8'h80, 8'd1},
    {16'h3A2B, 8'h96, 8'd0}
  };

  int checks = 0, fails = 0;
  bit finished = 0;
  int busyCnt;
  int orderErr;
  int lastOff;
  logic [7:0] capData [128];
  logic       capSeen [128];
  logic [8:0] capPage [128];
  logic [7:0] expData [128];
  logic       expMask [128];
  logic [8:0] expPage;
  logic [7:0] lastByte;
  logic togExp = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (busy) busyCnt++;
      if (commitValid) begin
        if (int'(commitAddr[6:0]) <= lastOff) orderErr++;
        lastOff = int'(commitAddr[6:0]);
        capSeen[commitAddr[6:0]] = 1'b1;
        capData[commitAddr[6:0]] = commitData;
        capPage[commitAddr[6:0]] = commitAddr[15:7];
      end
    end
  end

  task automatic clearScen();
    busyCnt = 0; orderErr = 0; lastOff = -1;
    for (int i = 0; i < 128; i++) begin
      capSeen[i] = 1'b0; expMask[i] = 1'b0;
    end
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [7:0] d, input int lowCyc,
                         input logic ceV, input logic oeV);
    addr = a; dataIn = d; ceN = ceV; oeN = oeV; weN = 1'b0;
    repeat (lowCyc) @(negedge clk);
    weN = 1'b1;
    @(negedge clk);
    ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic doRead(output logic drv, output logic [7:0] val);
    ceN = 1'b0; oeN = 1'b0;
    @(negedge clk);
    drv = rdDrive; val = rdData;
    ceN = 1'b1; oeN = 1'b1;
    @(negedge clk);
  endtask

  task automatic model(input logic [15:0] a, input logic [7:0] d, input bit first);
    if (first) expPage = a[15:7];
    expData[a[6:0]] = d; expMask[a[6:0]] = 1'b1; lastByte = d;
  endtask

  task automatic runOut(output bit rose);
    rose = 0;
    for (int k = 0; k < W + 10 && !rose; k++) begin
      @(negedge clk);
      if (busy) rose = 1;
    end
    while (busy) @(negedge clk);
  endtask

  task automatic compareCap(input string tag);
    int bad = 0, badPage = 0;
    for (int i = 0; i < 128; i++) begin
      if (capSeen[i] !== expMask[i]) bad++;
      else if (capSeen[i] && capData[i] !== expData[i]) bad++;
      if (capSeen[i] && capPage[i] !== expPage) badPage++;
    end
    check(bad == 0 && orderErr == 0, tag, bad + orderErr, 0);
    check(badPage == 0, "R4 page", badPage, 0);
  endtask

  initial begin
    logic drv; logic [7:0] val; bit rose;
    rstN = 1'b0; weN = 1'b1; ceN = 1'b1; oeN = 1'b1; protectOn = 1'b0;
    addr = '0; dataIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 0, "R1 busy", busy, 0);
    check(commitValid == 0, "R1 commitValid", commitValid, 0);
    check(rdDrive == 0, "R1 rdDrive", rdDrive, 0);
    check(rdData == 8'h00, "R1 rdData", rdData, 0);

    // Table walk: page burst with restarts, repeated offset, foreign page bits
    clearScen();
    foreach (VEC[i]) begin
      model(VEC[i][31:16], VEC[i][15:8], i == 0);
      doWrite(VEC[i][31:16], VEC[i][15:8], MINLOW, 1'b0, 1'b1);
      if (i < 5) repeat (int'(VEC[i][7:0])) @(negedge clk);
    end
    repeat (W - 1) @(negedge clk);
    check(busy == 0, "R5 before window", busy, 0);
    @(negedge clk);
    check(busy == 1, "R5 window end", busy, 1);
    doRead(drv, val);
    togExp = ~togExp;
    check(drv == 1, "R9 drive", drv, 1);
    check(val[7] == ~lastByte[7], "R9 bit7", val[7], ~lastByte[7]);
    check(val[5:0] == 6'd0, "R9 low bits", val[5:0], 0);
    check(val[6] == togExp, "R10 toggle1", val[6], togExp);
    doRead(drv, val);
    togExp = ~togExp;
    check(val[6] == togExp, "R10 toggle2", val[6], togExp);
    doWrite({expPage, 7'h7E}, 8'h5F, MINLOW, 1'b0, 1'b1);
    doRead(drv, val);
    togExp = ~togExp;
    check(val[7] == ~lastByte[7], "R11 status kept", val[7], ~lastByte[7]);
    while (busy) @(negedge clk);
    check(busyCnt == P, "R6 busy length", busyCnt, P);
    compareCap("R7 stream");
    doRead(drv, val);
    check(drv == 0, "R9 idle drive", drv, 0);
    check(val[7] == lastByte[7], "R10 true bit7", val[7], lastByte[7]);
    check(val[6] == togExp, "R10 toggle held", val[6], togExp);

    // Rejected writes, then one good byte
    clearScen();
    doWrite(16'h0400, 8'hAB, MINLOW - 1, 1'b0, 1'b1);
    repeat (W + 5) @(negedge clk);
    check(busy == 0, "R2 short pulse", busy, 0);
    doWrite(16'h0401, 8'hCD, MINLOW, 1'b1, 1'b1);
    repeat (W + 5) @(negedge clk);
    check(busy == 0, "R3 ce high", busy, 0);
    doWrite(16'h0402, 8'hEF, MINLOW, 1'b0, 1'b0);
    repeat (W + 5) @(negedge clk);
    check(busy == 0, "R3 oe low", busy, 0);
    model(16'h0403, 8'h3C, 1);
    doWrite(16'h0403, 8'h3C, MINLOW + 1, 1'b0, 1'b1);
    runOut(rose);
    check(rose, "R2 good pulse", rose, 1);
    compareCap("R3 only good byte");

    // Protection
    clearScen();
    protectOn = 1'b1;
    doWrite(16'h8105, 8'h77, MINLOW, 1'b0, 1'b1);
    repeat (W + 5) @(negedge clk);
    check(busy == 0, "R8 locked", busy, 0);
    doWrite(16'h5555, 8'hAA, MINLOW, 1'b0, 1'b1);
    doWrite(16'h2AAA, 8'h55, MINLOW, 1'b0, 1'b1);
    doWrite(16'h5555, 8'hA0, MINLOW, 1'b0, 1'b1);
    model(16'h8103, 8'h42, 1);
    doWrite(16'h8103, 8'h42, MINLOW, 1'b0, 1'b1);
    model(16'h8110, 8'h24, 0);
    doWrite(16'h8110, 8'h24, MINLOW, 1'b0, 1'b1);
    runOut(rose);
    check(rose, "R8 unlocked", rose, 1);
    compareCap("R8 unlock bytes not loaded");
    doWrite(16'h8120, 8'h11, MINLOW, 1'b0, 1'b1);
    repeat (W + 5) @(negedge clk);
    check(busy == 0, "R8 unlock consumed", busy, 0);
    protectOn = 1'b0;

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R6 watchdog act=running exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule